// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock of an I2C master from a much faster system clock. A timing word sets the clock's shape. It holds a power-of-two prescaler exponent and two zero-based counts, one for the low phase and one for the high phase. One SCL period is therefore `2^exp * (high + 1 + low + 1)` system clocks. The block drives the SCL line only by pulling it low (an open-drain low enable), and it watches the line as it comes back.

Each request runs exactly one bit period, low phase first and then high phase. The byte-level controller above the block owns the SDA line. It uses two strobes from this block: a launch strobe that tells it when to change SDA, and a sample strobe that tells it when to capture SDA near the middle of the high phase. If a slave holds SCL low after the block releases it (clock stretching), the high phase does not start counting until the line is really high. A stretch indicator shows this wait. Clear the enable to abort a bit at any time.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, `scl_low_o`, `busy_o`, `launch_o`, `sample_o`, `stretch_o` and `done_o` are all 0, and SCL is released.
- R2: When `en_i` and `bit_req_i` are both high while the block is idle, `scl_low_o` and `busy_o` rise at the next clock edge. `launch_o` is high for that first low cycle only, so it pulses exactly once per bit.
- R3: The low phase lasts `(lo + 1) * 2^exp` system clocks. The low count `lo` is taken from timing word bits 15:12 and the exponent `exp` from bits 3:0.
- R4: After the release, the high phase lasts `(hi + 1) * 2^exp` system clocks during which the SCL line is high. The high count `hi` is taken from bits 19:16. With no stretching, the whole bit takes `2^exp * (hi + lo + 2)` clocks.
- R5: In the high phase, every clock in which the SCL input is low is not counted, and `stretch_o` is high in the following cycle. Each such clock lengthens the bit by exactly one clock.
- R6: `sample_o` pulses exactly once per bit. It pulses in the cycle after the high phase has counted `((hi + 1) >> 1) * 2^exp` line-high clocks. For an odd total, the high half rounds so that the extra prescaled tick falls after the sample point.
- R7: `done_o` pulses for one cycle, in the first idle cycle after the high phase. A request presented in that same cycle starts the next bit at the next edge.
- R8: A timing word is taken only while the block is idle. Changing `timing_i` during a bit has no effect on that bit's phase lengths.
- R9: While `en_i` is low, the block goes idle and releases SCL at the next edge, and it ignores `bit_req_i`.
- R10: The extremes of the fields behave as in R3 and R4. Counts of 0 with exponent 0 give a two-clock bit. Counts of 15 give 16 prescaled ticks per phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Block enable; low aborts and idles the block |
| timing_i | input | WORD_W | Timing word: exponent [3:0], low count [15:12], high count [19:16] |
| bit_req_i | input | 1 | Request to run one bit period |
| scl_in_i | input | 1 | Synchronized level of the SCL line |
| scl_low_o | output | 1 | Open-drain enable: 1 pulls SCL low |
| busy_o | output | 1 | A bit period is in progress |
| launch_o | output | 1 | Strobe: change SDA at the end of this cycle |
| sample_o | output | 1 | Strobe: capture SDA at the end of this cycle |
| stretch_o | output | 1 | SCL released but still held low by the bus |
| done_o | output | 1 | One-cycle pulse at the end of a bit |

## Verification
The bench builds the block with its default parameters: a 4-bit exponent, 4-bit counts and a 32-bit word. It uses exponents from 0 to 3, so that bits with full 15-count fields, all-zero fields and odd totals each finish within a few hundred clocks. The scaling by the prescaler is still visible. A bench-side line model holds SCL low for a chosen number of clocks after each release, which brings stretching within reach. The bench also forces word changes in the middle of a bit, back-to-back requests on the done cycle, and aborts in the middle of the low phase.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;
endpackage

// File: rtl/sclgen_prescale.sv
module sclgen_prescale #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [EXP_W-1:0] exp_i,
    output logic             tick_o,
    output logic             at_zero_o
);
    localparam int PRE_W = (1 << EXP_W) - 1;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] lim;

    // An all-ones result covers the top exponent, where the shift wraps to zero.
    assign lim       = (PRE_W'(1) << exp_i) - PRE_W'(1);
    assign tick_o    = run && (pre_q == lim);
    assign at_zero_o = (pre_q == '0);

    always_comb begin
        pre_d = pre_q;
        if (clr)
            pre_d = '0;
        else if (run)
            pre_d = (pre_q == lim) ? '0 : pre_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R3
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pre_q <= lim));
endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign zero_o = (cnt_q == '0);
    assign cnt_o  = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (dec)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import sclgen_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int EXP_W  = 4,
    parameter int CNT_W  = 4,
    parameter int EXP_LSB = 0,
    parameter int LO_LSB  = 12,
    parameter int HI_LSB  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [WORD_W-1:0] timing_i,
    input  logic              bit_req_i,
    input  logic              scl_in_i,
    output logic              scl_low_o,
    output logic              busy_o,
    output logic              launch_o,
    output logic              sample_o,
    output logic              stretch_o,
    output logic              done_o
);
    typedef struct packed {
        phase_e           ph;
        logic [EXP_W-1:0] ex;
        logic [CNT_W-1:0] hi;
        logic             drv;
        logic             launch;
        logic             sample;
        logic             stretch;
        logic             done;
    } state_t;

    state_t s_d, s_q;

    logic [EXP_W-1:0] w_ex;
    logic [CNT_W-1:0] w_hi, w_lo;
    logic             pre_clr, pre_run, tick, pre_zero;
    logic             cnt_load, cnt_dec, cnt_zero;
    logic [CNT_W-1:0] cnt_val, cnt_q;
    logic [CNT_W:0]   hi_p1;
    logic [CNT_W-1:0] mid, elapsed;

    assign w_ex = timing_i[EXP_LSB +: EXP_W];
    assign w_lo = timing_i[LO_LSB  +: CNT_W];
    assign w_hi = timing_i[HI_LSB  +: CNT_W];

    assign hi_p1   = {1'b0, s_q.hi} + (CNT_W+1)'(1);
    assign mid     = hi_p1[CNT_W:1];
    assign elapsed = s_q.hi - cnt_q;

    sclgen_prescale #(.EXP_W(EXP_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pre_clr),
        .run       (pre_run),
        .exp_i     (s_q.ex),
        .tick_o    (tick),
        .at_zero_o (pre_zero)
    );

    sclgen_phase #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero_o   (cnt_zero),
        .cnt_o    (cnt_q)
    );

    always_comb begin
        s_d         = s_q;
        s_d.launch  = 1'b0;
        s_d.sample  = 1'b0;
        s_d.stretch = 1'b0;
        s_d.done    = 1'b0;
        pre_clr     = 1'b0;
        pre_run     = 1'b0;
        cnt_load    = 1'b0;
        cnt_val     = w_lo;
        cnt_dec     = 1'b0;
        if (!en_i) begin
            s_d.ph  = PH_IDLE;
            s_d.drv = 1'b0;
        end else begin
            unique case (s_q.ph)
                PH_IDLE: begin
                    s_d.ex = w_ex;
                    s_d.hi = w_hi;
                    if (bit_req_i) begin
                        s_d.ph     = PH_LOW;
                        s_d.drv    = 1'b1;
                        s_d.launch = 1'b1;
                        pre_clr    = 1'b1;
                        cnt_load   = 1'b1;
                        cnt_val    = w_lo;
                    end
                end
                PH_LOW: begin
                    pre_run = 1'b1;
                    if (tick) begin
                        if (cnt_zero) begin
                            s_d.ph   = PH_HIGH;
                            s_d.drv  = 1'b0;
                            pre_clr  = 1'b1;
                            cnt_load = 1'b1;
                            cnt_val  = s_q.hi;
                        end else begin
                            cnt_dec = 1'b1;
                        end
                    end
                end
                PH_HIGH: begin
                    pre_run     = scl_in_i;
                    s_d.stretch = !scl_in_i;
                    s_d.sample  = scl_in_i && pre_zero && (elapsed == mid);
                    if (tick) begin
                        if (cnt_zero) begin
                            s_d.ph   = PH_IDLE;
                            s_d.done = 1'b1;
                        end else begin
                            cnt_dec = 1'b1;
                        end
                    end
                end
                default: s_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_low_o = s_q.drv;
    assign busy_o    = (s_q.ph != PH_IDLE);
    assign launch_o  = s_q.launch;
    assign sample_o  = s_q.sample;
    assign stretch_o = s_q.stretch;
    assign done_o    = s_q.done;

    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && en_i && bit_req_i) |=> (scl_low_o && launch_o && busy_o));

    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!scl_low_o && !busy_o));

    // R5
    stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_o |-> (!scl_low_o && busy_o));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o || scl_low_o));

    // R6
    sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> (!scl_low_o && !launch_o));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && en_i) |=> (!busy_o || ($stable(s_q.hi) && $stable(s_q.ex))));
endmodule

// File: tb/scl_timing_gen_test.sv
`timescale 1ns/1ps
module scl_timing_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] word = '0;
    logic        req = 1'b0;
    logic        hold = 1'b0;
    logic        scl_line;
    logic        scl_low_o, busy_o, launch_o, sample_o, stretch_o, done_o;

    int checks = 0;
    int failures = 0;
    int stretch_n = 0;
    int hold_cnt = 0;
    logic prev_low = 1'b0;
    string tag = "R1";
    bit finished = 0;

    // Reference model state
    logic e_drive = 0, e_busy = 0, e_launch = 0, e_sample = 0, e_stretch = 0, e_done = 0;
    int   m_phase = 0, m_left = 0, m_hel = 0, m_cb = 0, m_chi = 0;

    always #4 clk = ~clk;

    assign scl_line = ~(scl_low_o | hold);

    scl_timing_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .timing_i  (word),
        .bit_req_i (req),
        .scl_in_i  (scl_line),
        .scl_low_o (scl_low_o),
        .busy_o    (busy_o),
        .launch_o  (launch_o),
        .sample_o  (sample_o),
        .stretch_o (stretch_o),
        .done_o    (done_o)
    );

    function automatic logic [31:0] mkw(input int e, input int h, input int l);
        return (32'(h) << 16) | (32'(l) << 12) | 32'(e);
    endfunction

    task automatic check_eq(input string name, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", name, act, exp);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Behavioural reference: one step per rising edge
    always @(posedge clk) begin
        bit line;
        line = !e_drive && !hold;
        e_launch = 0; e_sample = 0; e_stretch = 0; e_done = 0;
        if (!rst_n) begin
            e_drive = 0; e_busy = 0; m_phase = 0;
        end else if (!en) begin
            e_drive = 0; e_busy = 0;
        end else if (!e_busy) begin
            if (req) begin
                m_cb    = int'(word[3:0]);
                m_chi   = int'(word[19:16]);
                m_left  = (int'(word[15:12]) + 1) << m_cb;
                m_phase = 0;
                e_busy  = 1; e_drive = 1; e_launch = 1;
            end
        end else if (m_phase == 0) begin
            m_left--;
            if (m_left == 0) begin
                m_phase = 1;
                m_left  = (m_chi + 1) << m_cb;
                m_hel   = 0;
                e_drive = 0;
            end
        end else begin
            if (!line) begin
                e_stretch = 1;
            end else begin
                if (m_hel == (((m_chi + 1) >> 1) << m_cb)) e_sample = 1;
                m_hel++;
                m_left--;
                if (m_left == 0) begin
                    e_busy = 0; e_done = 1;
                end
            end
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        logic [5:0] act, exp;
        act = {scl_low_o, busy_o, launch_o, sample_o, stretch_o, done_o};
        exp = {e_drive, e_busy, e_launch, e_sample, e_stretch, e_done};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s per-cycle outputs: actual=%b expected=%b", tag, act, exp);
        end
    end

    // Bus model: hold SCL low for stretch_n clocks after each release
    always @(negedge clk) begin
        if (prev_low && !scl_low_o) hold_cnt = stretch_n;
        hold = (hold_cnt > 0);
        if (hold_cnt > 0) hold_cnt--;
        prev_low = scl_low_o;
    end

    task automatic run_bit(input logic [31:0] w, input int n_str, input bit swap,
                           input logic [31:0] alt, input string t);
        int lc = 0, hc = 0, sc = 0, lac = 0, stc = 0;
        int e, h, l;
        e = int'(w[3:0]); h = int'(w[19:16]); l = int'(w[15:12]);
        tag = t;
        stretch_n = n_str;
        @(negedge clk);
        word = w; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        if (swap) word = alt;
        while (!done_o) begin
            if (scl_low_o) lc++;
            if (busy_o && !scl_low_o) hc++;
            if (sample_o) sc++;
            if (launch_o) lac++;
            if (stretch_o) stc++;
            @(negedge clk);
        end
        if (sample_o) sc++;
        check_eq({t, " R3 low phase clocks"}, lc, (l + 1) << e);
        check_eq({t, " R4 high phase clocks"}, hc, ((h + 1) << e) + n_str);
        check_eq({t, " R2 launch pulses"}, lac, 1);
        check_eq({t, " R6 sample pulses"}, sc, 1);
        check_eq({t, " R5 stretch cycles"}, stc, n_str);
        stretch_n = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        check_eq("R1 reset outputs", int'({scl_low_o, busy_o, launch_o, sample_o, stretch_o, done_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 idle after reset", int'({scl_low_o, busy_o}), 0);
        en = 1'b1;

        run_bit(mkw(0, 2, 3), 0, 0, '0, "R3");
        run_bit(mkw(1, 5, 2), 0, 0, '0, "R4");
        run_bit(mkw(3, 4, 2), 0, 0, '0, "R6");
        run_bit(mkw(1, 2, 1), 0, 0, '0, "R6 odd");
        run_bit(mkw(0, 0, 0), 0, 0, '0, "R10 zero");
        run_bit(mkw(2, 15, 15), 0, 0, '0, "R10 max");
        run_bit(mkw(1, 3, 1), 5, 0, '0, "R5");
        run_bit(mkw(0, 1, 2), 1, 0, '0, "R5 short");
        run_bit(mkw(1, 2, 2), 0, 1, mkw(3, 9, 9), "R8");

        // R7: request in the done cycle starts the next bit at once
        tag = "R7";
        word = mkw(0, 1, 1);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check_eq("R7 back-to-back start", int'(scl_low_o), 1);
        while (!done_o) @(negedge clk);

        // R9: abort in the middle of the low phase, then ignore requests
        tag = "R9";
        @(negedge clk);
        word = mkw(1, 3, 4); req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check_eq("R9 abort releases SCL", int'({scl_low_o, busy_o}), 0);
        req = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R9 request ignored while disabled", int'({scl_low_o, busy_o}), 0);
        req = 1'b0;
        en = 1'b1;
        run_bit(mkw(0, 3, 3), 0, 0, '0, "R9 resume");

        repeat (4) @(negedge clk);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end
endmodule